// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the fetch and pre-decode front end of a small 8-bit controller core. Program memory is addressed in bytes, and each instruction is one or two 16-bit words. The block holds a 21-bit program counter and reads one word at a time through a synchronous read port. It sorts each word into an instruction class. For the two-word classes it waits for the continuation word and presents the whole operand as a single decoded instruction. It redirects the program counter itself for absolute jumps and relative branches.

The execute stage can ask for the next word to be skipped. A skip always steps over exactly one word. Every continuation word starts with the nibble 1111, so a continuation word that is reached on its own decodes as a no-operation. A skip therefore stays safe even when the next instruction is two words long.

A read is issued in one cycle and the data is used in the next, so each word takes two cycles. Each decoded instruction is a one-cycle pulse on `dec_valid`.

Top module: `dual_word_fetch`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted, and in the first cycle after it, `dec_valid` is 0 and `mem_addr` is 0. A two-word instruction that was only half fetched when reset came is dropped, and fetch restarts at byte address 0.
- R2: `mem_rd` is high for exactly one cycle in every two, and `mem_addr` is then always even. After a one-word instruction or a no-operation the next read address is that word's address plus 2. After a move it is the first word's address plus 4. `mem_rdata` is taken to be valid in the cycle after `mem_rd`.
- R3: A word that is not a continuation, a move, a jump or a branch is a plain instruction. It gives class 1 with `dec_opnd_a` = the word, zero-extended, and `dec_opnd_b` = 0.
- R4: A first word with top nibble 0xC is a move. After its second word arrives, the block gives one output of class 4 with `dec_opnd_a` = the first word bits 11:0 and `dec_opnd_b` = the second word bits 11:0. For example, 0xC123 followed by 0xF456 gives 0x123 and 0x456.
- R5: A first word with top byte 0xEF is an absolute jump. Its 20-bit word target is {second word bits 11:0, first word bits 7:0}. The output has class 3 and `dec_opnd_a` = that target, and the next read is at byte address target×2. For example, 0xEF03 followed by 0xF000 jumps to byte address 0x000006.
- R6: A word whose top five bits are 11010 is a relative branch. Its 11-bit signed offset is in bits 10:0. The output has class 2 and `dec_opnd_a` = the offset sign-extended to 20 bits. The next read is at (branch address + 2 + 2×offset) modulo 2^21.
- R7: A word with top nibble 0xF that is fetched as a first word gives a no-operation: class 0, with both operands 0.
- R8: If `skip_req` is high in a cycle where `dec_valid` is high, the next fetched word is thrown away with no output, and fetch goes on at the following word. When the word thrown away is the first half of a two-word instruction, its continuation word then comes out as a no-operation (R7).
- R9: `skip_req` has no effect in cycles where `dec_valid` is low.
- R10: `dec_pc` is the byte address of the first word of the decoded instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 21 | Byte address of the word being read |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after `mem_rd` |
| skip_req | input | 1 | Skip request from the execute stage |
| dec_valid | output | 1 | One-cycle pulse for each decoded instruction |
| dec_class | output | 3 | 0 nop, 1 plain, 2 branch, 3 jump, 4 move |
| dec_pc | output | 21 | Byte address of the instruction's first word |
| dec_opnd_a | output | 20 | Primary operand, as set by the class |
| dec_opnd_b | output | 12 | Move destination, 0 for every other class |

## Verification
The bench targets a skip that lands on the first half of a move. A design that skipped the whole instruction would never show the no-operation at the continuation address, and one that decoded that continuation as a real instruction would show the wrong class. A skip on a plain word followed by a lone continuation word checks that exactly one word is dropped. Both branch directions are tested, along with a jump to the top of the 21-bit space whose following branch wraps to address 0; an adder that forgets the extra 2, the doubling or the sign extension lands on the wrong word. A reset in the middle of a jump, with `skip_req` held high while no output is valid, must restart cleanly. A design that kept the half-built jump, or that latched that skip, would report the wrong first or second instruction.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_PLAIN  = 3'd1,
    CLS_BRANCH = 3'd2,
    CLS_JUMP   = 3'd3,
    CLS_MOVE   = 3'd4
  } ins_class_e;

  typedef enum logic [1:0] {
    ST_REQ1 = 2'd0,
    ST_DAT1 = 2'd1,
    ST_REQ2 = 2'd2,
    ST_DAT2 = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/dwf_classify.sv
// Pre-decode of one fetched word into the classes the sequencer cares about.
module dwf_classify #(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 11
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_cont,
  output logic              is_move1,
  output logic              is_jump1,
  output logic              is_branch,
  output logic [OFS_W-1:0]  br_off
);
  localparam logic [3:0] CONT_NIB = 4'hF;
  localparam logic [3:0] MOVE_NIB = 4'hC;
  localparam logic [7:0] JUMP_HI  = 8'hEF;
  localparam logic [4:0] BR_HI    = 5'b11010;

  always_comb begin
    is_cont   = (word[WORD_W-1 -: 4] == CONT_NIB);
    is_move1  = (word[WORD_W-1 -: 4] == MOVE_NIB);
    is_jump1  = (word[WORD_W-1 -: 8] == JUMP_HI);
    is_branch = (word[WORD_W-1 -: 5] == BR_HI);
    br_off    = word[OFS_W-1:0];
  end
endmodule

// File: rtl/dwf_target.sv
// Next-PC candidates: sequential, relative branch, absolute jump.
module dwf_target #(
  parameter int PC_W  = 21,
  parameter int OFS_W = 11,
  parameter int JW    = 20
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] br_off,
  input  logic [JW-1:0]    jmp_word,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  br_pc,
  output logic [PC_W-1:0]  jmp_pc
);
  localparam int EXT_W = PC_W - OFS_W - 1;

  logic [PC_W-1:0] br_bytes;

  always_comb begin
    seq_pc   = pc + PC_W'(2);
    br_bytes = {{EXT_W{br_off[OFS_W-1]}}, br_off, 1'b0};
    br_pc    = seq_pc + br_bytes;
    jmp_pc   = PC_W'({jmp_word, 1'b0});
  end
endmodule

// File: rtl/dual_word_fetch.sv
module dual_word_fetch #(
  parameter int PC_W   = 21,
  parameter int WORD_W = 16,
  parameter int OFS_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic [PC_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              skip_req,
  output logic              dec_valid,
  output logic [2:0]        dec_class,
  output logic [PC_W-1:0]   dec_pc,
  output logic [PC_W-2:0]   dec_opnd_a,
  output logic [WORD_W-5:0] dec_opnd_b
);
  import dwf_pkg::*;

  localparam int OPA_W = PC_W - 1;
  localparam int OPB_W = WORD_W - 4;
  localparam int JW    = OPB_W + 8;
  localparam int EXT_W = OPA_W - OFS_W;

  fetch_st_e        st;
  logic [PC_W-1:0]  pc;
  logic [PC_W-1:0]  first_pc;
  logic [OPB_W-1:0] hold_lo;
  logic             hold_jump;
  logic             skip_arm;

  logic             w_cont, w_move1, w_jump1, w_branch;
  logic [OFS_W-1:0] w_off;
  logic [JW-1:0]    jmp_word;
  logic [PC_W-1:0]  seq_pc, br_pc, jmp_pc;

  dwf_classify #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_cls (
    .word      (mem_rdata),
    .is_cont   (w_cont),
    .is_move1  (w_move1),
    .is_jump1  (w_jump1),
    .is_branch (w_branch),
    .br_off    (w_off)
  );

  assign jmp_word = {mem_rdata[OPB_W-1:0], hold_lo[7:0]};

  dwf_target #(.PC_W(PC_W), .OFS_W(OFS_W), .JW(JW)) u_tgt (
    .pc       (pc),
    .br_off   (w_off),
    .jmp_word (jmp_word),
    .seq_pc   (seq_pc),
    .br_pc    (br_pc),
    .jmp_pc   (jmp_pc)
  );

  assign mem_rd   = (st == ST_REQ1) || (st == ST_REQ2);
  assign mem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_REQ1;
      pc         <= '0;
      first_pc   <= '0;
      hold_lo    <= '0;
      hold_jump  <= 1'b0;
      skip_arm   <= 1'b0;
      dec_valid  <= 1'b0;
      dec_class  <= CLS_NOP;
      dec_pc     <= '0;
      dec_opnd_a <= '0;
      dec_opnd_b <= '0;
    end else begin
      dec_valid <= 1'b0;
      case (st)
        ST_REQ1: begin
          if (dec_valid && skip_req) skip_arm <= 1'b1;
          st <= ST_DAT1;
        end
        ST_DAT1: begin
          st <= ST_REQ1;
          pc <= seq_pc;
          if (skip_arm) begin
            skip_arm <= 1'b0;
          end else if (w_cont) begin
            dec_valid  <= 1'b1;
            dec_class  <= CLS_NOP;
            dec_pc     <= pc;
            dec_opnd_a <= '0;
            dec_opnd_b <= '0;
          end else if (w_move1 || w_jump1) begin
            hold_lo   <= mem_rdata[OPB_W-1:0];
            hold_jump <= w_jump1;
            first_pc  <= pc;
            st        <= ST_REQ2;
          end else if (w_branch) begin
            pc         <= br_pc;
            dec_valid  <= 1'b1;
            dec_class  <= CLS_BRANCH;
            dec_pc     <= pc;
            dec_opnd_a <= {{EXT_W{w_off[OFS_W-1]}}, w_off};
            dec_opnd_b <= '0;
          end else begin
            dec_valid  <= 1'b1;
            dec_class  <= CLS_PLAIN;
            dec_pc     <= pc;
            dec_opnd_a <= OPA_W'(mem_rdata);
            dec_opnd_b <= '0;
          end
        end
        ST_REQ2: st <= ST_DAT2;
        ST_DAT2: begin
          st        <= ST_REQ1;
          dec_valid <= 1'b1;
          dec_pc    <= first_pc;
          if (hold_jump) begin
            pc         <= jmp_pc;
            dec_class  <= CLS_JUMP;
            dec_opnd_a <= OPA_W'(jmp_word);
            dec_opnd_b <= '0;
          end else begin
            pc         <= seq_pc;
            dec_class  <= CLS_MOVE;
            dec_opnd_a <= OPA_W'(hold_lo);
            dec_opnd_b <= mem_rdata[OPB_W-1:0];
          end
        end
        default: st <= ST_REQ1;
      endcase
    end
  end
endmodule

// File: rtl/dwf_chk.sv
module dwf_chk #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_rd,
  input logic [PC_W-1:0] mem_addr,
  input logic            dec_valid,
  input logic [2:0]      dec_class,
  input logic [PC_W-1:0] dec_pc,
  input logic [PC_W-2:0] dec_opnd_a
);
  import dwf_pkg::*;

  logic rst_q = 1'b0;
  always @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_q) begin
      reset_state_chk: assert (!dec_valid && mem_addr == '0);
    end
  end

  // R2
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R2
  even_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !mem_addr[0]);

  // R3
  plain_next_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == CLS_PLAIN) |-> mem_addr == dec_pc + PC_W'(2));

  // R4
  move_next_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == CLS_MOVE) |-> mem_addr == dec_pc + PC_W'(4));

  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == CLS_JUMP) |-> mem_addr == {dec_opnd_a, 1'b0});

  // R6
  branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == CLS_BRANCH) |->
      mem_addr == dec_pc + PC_W'(2) + {dec_opnd_a, 1'b0});

  // R7
  nop_next_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class == CLS_NOP) |-> mem_addr == dec_pc + PC_W'(2));

  // R8
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
endmodule

bind dual_word_fetch dwf_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .dec_valid  (dec_valid),
  .dec_class  (dec_class),
  .dec_pc     (dec_pc),
  .dec_opnd_a (dec_opnd_a)
);

// File: tb/sim_dual_word_fetch.sv
`timescale 1ns/1ps
module sim_dual_word_fetch;
  localparam int PC_W = 21;
  localparam int NV   = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        skip_req = 1'b0;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        dec_valid;
  logic [2:0]  dec_class;
  logic [20:0] dec_pc;
  logic [19:0] dec_opnd_a;
  logic [11:0] dec_opnd_b;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_word_fetch u0 (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .skip_req(skip_req), .dec_valid(dec_valid),
    .dec_class(dec_class), .dec_pc(dec_pc), .dec_opnd_a(dec_opnd_a),
    .dec_opnd_b(dec_opnd_b)
  );

  logic [15:0] mem [64];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[6:1]];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog R2: actual cycles=%0d expected <= 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // vector: pc, class, opnd_a, opnd_b, skip after this output
  localparam logic [56:0] VEC [NV] = '{
    {21'h000000, 3'd1, 20'h00E55, 12'h000, 1'b0},
    {21'h000002, 3'd3, 20'h00008, 12'h000, 1'b0},
    {21'h000010, 3'd4, 20'h00123, 12'h456, 1'b0},
    {21'h000014, 3'd1, 20'h06600, 12'h000, 1'b1},
    {21'h000018, 3'd0, 20'h00000, 12'h000, 1'b0},
    {21'h00001A, 3'd1, 20'h02400, 12'h000, 1'b1},
    {21'h00001E, 3'd0, 20'h00000, 12'h000, 1'b0},
    {21'h000020, 3'd2, 20'h00002, 12'h000, 1'b0},
    {21'h000026, 3'd2, 20'h00001, 12'h000, 1'b0},
    {21'h00002A, 3'd2, 20'hFFFEE, 12'h000, 1'b0},
    {21'h000008, 3'd1, 20'h04444, 12'h000, 1'b0},
    {21'h00000A, 3'd3, 20'h00018, 12'h000, 1'b0},
    {21'h000030, 3'd3, 20'hFFFFF, 12'h000, 1'b0},
    {21'h1FFFFE, 3'd2, 20'h00000, 12'h000, 1'b0},
    {21'h000000, 3'd1, 20'h00E55, 12'h000, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (dec_valid !== 1'b1);
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0:    return "R7";
      3'd2:    return "R6";
      3'd3:    return "R5";
      3'd4:    return "R4";
      default: return "R3";
    endcase
  endfunction

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 16'h0000;
    mem[0]  = 16'h0E55; mem[1]  = 16'hEF08; mem[2]  = 16'hF000;
    mem[3]  = 16'h1234; mem[4]  = 16'h4444; mem[5]  = 16'hEF18;
    mem[6]  = 16'hF000; mem[8]  = 16'hC123; mem[9]  = 16'hF456;
    mem[10] = 16'h6600; mem[11] = 16'hC111; mem[12] = 16'hF222;
    mem[13] = 16'h2400; mem[14] = 16'h0001; mem[15] = 16'hF777;
    mem[16] = 16'hD002; mem[17] = 16'h1111; mem[18] = 16'h1111;
    mem[19] = 16'hD001; mem[20] = 16'h3333; mem[21] = 16'hD7EE;
    mem[24] = 16'hEFFF; mem[25] = 16'hFFFF; mem[63] = 16'hD000;

    repeat (3) @(negedge clk);
    chk("R1", {dec_valid, mem_addr}, 22'h0);  // reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      automatic logic [56:0] v = VEC[i];
      automatic logic [20:0] epc = v[56:36];
      automatic logic [2:0]  ecl = v[35:33];
      automatic logic [19:0] eoa = v[32:13];
      automatic logic [11:0] eob = v[12:1];
      automatic logic [20:0] nx;
      automatic string tg = (i > 0 && VEC[i-1][0]) ? "R8" : tag_of(ecl);
      case (ecl)
        3'd4:    nx = epc + 21'd4;
        3'd3:    nx = {eoa, 1'b0};
        3'd2:    nx = epc + 21'd2 + {eoa, 1'b0};
        default: nx = epc + 21'd2;
      endcase
      wait_valid();
      chk(tg, {dec_class, dec_opnd_a, dec_opnd_b}, {ecl, eoa, eob});
      chk("R10", dec_pc, epc);
      chk("R2", mem_addr, nx);
      skip_req = v[0];
      @(negedge clk);
      skip_req = 1'b0;
    end

    // reset in the middle of a two-word jump (R1), skip held while idle (R9)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do @(negedge clk); while (!(mem_rd === 1'b1 && mem_addr == 21'h4));
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {dec_valid, mem_addr}, 22'h0);
    @(negedge clk);
    skip_req = 1'b1;
    rst = 1'b0;
    wait_valid();
    chk("R1", dec_pc, 21'h0);
    chk("R9", dec_class, 3'd1);
    skip_req = 1'b0;
    wait_valid();
    chk("R9", dec_pc, 21'h2);
    chk("R5", {dec_class, dec_opnd_a}, {3'd3, 20'h00008});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule